// File: doc/BRIEF.md
# Memory Access Handshake Unit

This unit sits between a processor's single internal data bus and an external memory bus whose response time varies from one access to the next. It keeps two registers. The address register takes its value from the internal bus and drives the memory address lines at all times. The data register can be loaded from the internal bus or from the memory read lines, and it can be driven onto the internal bus or onto the memory write lines. Each of those four paths has its own gate.

The controller issues a read or write command. The unit then raises a memory request and holds it until the memory returns a completion pulse. In a step marked as waiting for completion, the unit raises a stall so the controller's step counter stays frozen. When a read completes, the data register captures the read lines on the same edge that samples the completion pulse. After that the controller can move the data register onto the internal bus. During a write, the data register is driven onto the write lines for as long as the request lasts. A command that arrives while an access is still outstanding is dropped and reported for one cycle.

Top module: `mem_handshake`

## Requirements
- R1: After a synchronous reset, `mem_req`, `mem_we`, `stall`, `cmd_error` and `mem_wdata_en` are 0. `mem_addr` is 0. The data register, seen on `bus_out`, is 0.
- R2: The address register loads `bus_in[ADDR_W-1:0]` on a clock edge where `addr_load` is 1, and otherwise holds its value. `mem_addr` always shows the address register.
- R3: The data register loads `bus_in` on an edge where `mdr_load_bus` is 1. `bus_out` always shows the data register, and `bus_out_en` equals `mdr_drive_bus`.
- R4: The data register loads `mem_rdata` on an edge where `mdr_load_mem` is 1. If `mdr_load_bus` is also 1 on that edge, the memory-side load wins.
- R5: A `cmd_read` or `cmd_write` accepted while idle raises `mem_req` from the next cycle. `mem_req` stays 1 until the edge that samples `mem_cpl` at 1, and is 0 from the following cycle.
- R6: During an outstanding read (`mem_we` = 0), the data register captures `mem_rdata` on the edge where `mem_cpl` is sampled at 1, with no gate input needed.
- R7: During an outstanding write, `mem_we` and `mem_wdata_en` are 1 and `mem_wdata` equals the data register. The data register is not changed by the completion of a write.
- R8: `mdr_drive_mem` set to 1 forces `mem_wdata_en` to 1 even when no access is outstanding.
- R9: `stall` is 1 exactly when `wait_cpl` is 1, a request is outstanding, and `mem_cpl` is 0.
- R10: A command that arrives while a request is outstanding is ignored: the access type is unchanged and no extra access occurs. `cmd_read` and `cmd_write` together in one cycle are ignored as well. In both cases `cmd_error` is 1 for exactly the next cycle.
- R11: A `mem_cpl` pulse with no request outstanding has no effect: `mem_req` stays 0 and the data register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_in | input | DATA_W | Value on the internal bus |
| addr_load | input | 1 | Load address register from internal bus |
| mdr_load_bus | input | 1 | Load data register from internal bus |
| mdr_load_mem | input | 1 | Load data register from memory read lines |
| mdr_drive_bus | input | 1 | Gate data register onto internal bus |
| mdr_drive_mem | input | 1 | Gate data register onto memory write lines |
| cmd_read | input | 1 | Start a read access |
| cmd_write | input | 1 | Start a write access |
| wait_cpl | input | 1 | Current step waits for memory completion |
| mem_cpl | input | 1 | Completion pulse from memory |
| mem_rdata | input | DATA_W | Memory read data lines |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_wdata | output | DATA_W | Memory write data lines |
| mem_wdata_en | output | 1 | Write data lines are driven |
| mem_req | output | 1 | Memory request outstanding |
| mem_we | output | 1 | Outstanding request is a write |
| bus_out | output | DATA_W | Data register value toward internal bus |
| bus_out_en | output | 1 | Data register drives internal bus |
| stall | output | 1 | Hold controller step counter |
| cmd_error | output | 1 | Previous cycle carried an ignored command |

## Verification
The assertions assume that `mem_cpl` is only meaningful while `mem_req` is high and that it is a single-cycle pulse. They also assume the controller keeps `wait_cpl` high until the stall drops. The bench models memory as a small array whose completion arrives after a latency taken from each vector, including zero, which means the pulse lands in the first request cycle. `wait_cpl` is held for the whole request window. Stray completion pulses, overlapping commands and dual commands are applied only in directed tests, where each of them is the subject of a check.

// File: rtl/mem_hs_pkg.sv
`timescale 1ns/1ps
package mem_hs_pkg;

    typedef enum logic {
        ACC_READ  = 1'b0,
        ACC_WRITE = 1'b1
    } acc_kind_e;

    typedef struct packed {
        logic      active;
        acc_kind_e kind;
    } acc_state_t;

    typedef struct packed {
        logic      valid;    // exactly one command line high
        logic      any;      // at least one command line high
        acc_kind_e kind;
    } cmd_dec_t;

    function automatic cmd_dec_t decode_cmd(input logic rd, input logic wr);
        cmd_dec_t d;
        d.valid = rd ^ wr;
        d.any   = rd | wr;
        d.kind  = wr ? ACC_WRITE : ACC_READ;
        return d;
    endfunction

endpackage

// File: rtl/mhs_addr_reg.sv
`timescale 1ns/1ps
module mhs_addr_reg #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] d,
    output logic [ADDR_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    AST_ADDR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q)); // R2
endmodule

// File: rtl/mhs_data_reg.sv
`timescale 1ns/1ps
module mhs_data_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_bus,
    input  logic              ld_mem,
    input  logic [DATA_W-1:0] bus_d,
    input  logic [DATA_W-1:0] mem_d,
    output logic [DATA_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)         q <= '0;
        else if (ld_mem) q <= mem_d;
        else if (ld_bus) q <= bus_d;
    end

    AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ld_bus && !ld_mem) |=> $stable(q)); // R11
    AST_MEM_WINS: assert property (@(posedge clk) disable iff (rst)
        ld_mem |=> (q == $past(mem_d))); // R4
endmodule

// File: rtl/mhs_req_ctrl.sv
`timescale 1ns/1ps
module mhs_req_ctrl
    import mem_hs_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_read,
    input  logic cmd_write,
    input  logic wait_cpl,
    input  logic mem_cpl,
    output logic req,
    output logic we,
    output logic read_done,
    output logic stall,
    output logic cmd_error
);
    acc_state_t st;
    cmd_dec_t   dec;
    logic       accept;
    logic       reject;

    always_comb begin
        dec    = decode_cmd(cmd_read, cmd_write);
        accept = dec.valid && !st.active;
        reject = dec.any && !accept;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= '{active: 1'b0, kind: ACC_READ};
            cmd_error <= 1'b0;
        end else begin
            cmd_error <= reject;
            if (accept) begin
                st.active <= 1'b1;
                st.kind   <= dec.kind;
            end else if (st.active && mem_cpl) begin
                st.active <= 1'b0;
            end
        end
    end

    assign req       = st.active;
    assign we        = st.active && (st.kind == ACC_WRITE);
    assign read_done = st.active && (st.kind == ACC_READ) && mem_cpl;
    assign stall     = wait_cpl && st.active && !mem_cpl;

    AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (req && !mem_cpl) |=> req); // R5
    AST_REQ_DROPS: assert property (@(posedge clk) disable iff (rst)
        (req && mem_cpl) |=> !req); // R5
    AST_STALL_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
        stall |=> req); // R9
    AST_BUSY_CMD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (req && (cmd_read || cmd_write)) |=> cmd_error); // R10
    AST_KIND_STABLE: assert property (@(posedge clk) disable iff (rst)
        (req && !mem_cpl) |=> $stable(we)); // R10
    AST_NO_IDLE_REQ: assert property (@(posedge clk) disable iff (rst)
        (!req && !cmd_read && !cmd_write) |=> !req); // R11
endmodule

// File: rtl/mem_handshake.sv
`timescale 1ns/1ps
module mem_handshake #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              addr_load,
    input  logic              mdr_load_bus,
    input  logic              mdr_load_mem,
    input  logic              mdr_drive_bus,
    input  logic              mdr_drive_mem,
    input  logic              cmd_read,
    input  logic              cmd_write,
    input  logic              wait_cpl,
    input  logic              mem_cpl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_out_en,
    output logic              stall,
    output logic              cmd_error
);
    localparam int ADDR_LSB_W = (ADDR_W < DATA_W) ? ADDR_W : DATA_W;

    logic [DATA_W-1:0] mdr_q;
    logic              read_done;
    logic              mem_side_load;

    mhs_addr_reg #(.ADDR_W(ADDR_LSB_W)) u_addr (
        .clk  (clk),
        .rst  (rst),
        .load (addr_load),
        .d    (bus_in[ADDR_LSB_W-1:0]),
        .q    (mem_addr)
    );

    mhs_req_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_read  (cmd_read),
        .cmd_write (cmd_write),
        .wait_cpl  (wait_cpl),
        .mem_cpl   (mem_cpl),
        .req       (mem_req),
        .we        (mem_we),
        .read_done (read_done),
        .stall     (stall),
        .cmd_error (cmd_error)
    );

    assign mem_side_load = mdr_load_mem || read_done;

    mhs_data_reg #(.DATA_W(DATA_W)) u_data (
        .clk    (clk),
        .rst    (rst),
        .ld_bus (mdr_load_bus),
        .ld_mem (mem_side_load),
        .bus_d  (bus_in),
        .mem_d  (mem_rdata),
        .q      (mdr_q)
    );

    assign bus_out      = mdr_q;
    assign bus_out_en   = mdr_drive_bus;
    assign mem_wdata    = mdr_q;
    assign mem_wdata_en = mdr_drive_mem || mem_we;

    AST_READ_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_cpl) |=> (bus_out == $past(mem_rdata))); // R6
    AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_wdata_en && mem_req)); // R7
    AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !mdr_load_bus && !mdr_load_mem) |=> $stable(mem_wdata)); // R7
endmodule

// File: tb/tb_mem_handshake.sv
`timescale 1ns/1ps
module tb_mem_handshake;
    localparam int DW = 16;
    localparam int AW = 12;
    localparam int NV = 8;

    logic clk = 1'b0;
    logic rst;
    logic [DW-1:0] bus_in;
    logic addr_load, mdr_load_bus, mdr_load_mem, mdr_drive_bus, mdr_drive_mem;
    logic cmd_read, cmd_write, wait_cpl, mem_cpl;
    logic [DW-1:0] mem_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, bus_out;
    logic mem_wdata_en, mem_req, mem_we, bus_out_en, stall, cmd_error;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [16];

    always #10 clk = ~clk;

    mem_handshake #(.DATA_W(DW), .ADDR_W(AW)) dut (
        .clk(clk), .rst(rst), .bus_in(bus_in), .addr_load(addr_load),
        .mdr_load_bus(mdr_load_bus), .mdr_load_mem(mdr_load_mem),
        .mdr_drive_bus(mdr_drive_bus), .mdr_drive_mem(mdr_drive_mem),
        .cmd_read(cmd_read), .cmd_write(cmd_write), .wait_cpl(wait_cpl),
        .mem_cpl(mem_cpl), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_wdata_en(mem_wdata_en), .mem_req(mem_req),
        .mem_we(mem_we), .bus_out(bus_out), .bus_out_en(bus_out_en),
        .stall(stall), .cmd_error(cmd_error)
    );

    // {write, addr[11:0], data[15:0], latency[7:0]}
    localparam logic [36:0] VEC [NV] = '{
        {1'b1, 12'h003, 16'hA5C3, 8'd2},
        {1'b1, 12'h00C, 16'h1234, 8'd0},
        {1'b1, 12'h7F5, 16'hFFFF, 8'd5},
        {1'b0, 12'h003, 16'h0000, 8'd1},
        {1'b0, 12'h00C, 16'h0000, 8'd0},
        {1'b0, 12'h7F5, 16'h0000, 8'd7},
        {1'b1, 12'h003, 16'h0F0F, 8'd3},
        {1'b0, 12'h003, 16'h0000, 8'd4}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_in = '0; addr_load = 0; mdr_load_bus = 0; mdr_load_mem = 0;
        mdr_drive_bus = 0; mdr_drive_mem = 0; cmd_read = 0; cmd_write = 0;
        wait_cpl = 0; mem_cpl = 0; mem_rdata = '0;
    endtask

    task automatic access(input logic wr, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input int lat);
        logic [DW-1:0] exp_rd;
        @(negedge clk); bus_in = DW'(a); addr_load = 1;
        @(negedge clk); addr_load = 0;
        chk("R2 mar load", 32'(mem_addr), 32'(a));
        if (wr) begin bus_in = d; mdr_load_bus = 1; end
        @(negedge clk); mdr_load_bus = 0; bus_in = 16'hDEAD;
        cmd_read = !wr; cmd_write = wr;
        @(negedge clk); cmd_read = 0; cmd_write = 0; wait_cpl = 1;
        mem_rdata = wr ? ~d : 16'hBEEF;
        for (int i = 0; i < lat; i++) begin
            #1;
            chk("R5 req held", 32'(mem_req), 1);
            chk("R9 stall while waiting", 32'(stall), 1);
            chk("R7 we type", 32'(mem_we), 32'(wr));
            if (wr) begin
                chk("R7 wdata_en", 32'(mem_wdata_en), 1);
                chk("R7 wdata", 32'(mem_wdata), 32'(d));
            end
            @(negedge clk);
        end
        exp_rd = model[a[3:0]];
        mem_cpl = 1;
        if (!wr) mem_rdata = exp_rd;
        #1;
        chk("R5 req at cpl", 32'(mem_req), 1);
        chk("R9 stall drops on cpl", 32'(stall), 0);
        @(negedge clk); mem_cpl = 0; wait_cpl = 0; mem_rdata = 16'h5555;
        mdr_drive_bus = 1;
        #1;
        chk("R5 req dropped", 32'(mem_req), 0);
        chk("R3 bus_out_en", 32'(bus_out_en), 1);
        if (wr) begin
            model[a[3:0]] = d;
            chk("R7 mdr kept after write", 32'(bus_out), 32'(d));
        end else begin
            chk("R6 read capture", 32'(bus_out), 32'(exp_rd));
        end
        @(negedge clk); mdr_drive_bus = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int k = 0; k < 16; k++) model[k] = '0;
        idle_inputs();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R1 reset state
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 we", 32'(mem_we), 0);
        chk("R1 stall", 32'(stall), 0);
        chk("R1 err", 32'(cmd_error), 0);
        chk("R1 wdata_en", 32'(mem_wdata_en), 0);
        chk("R1 addr", 32'(mem_addr), 0);
        chk("R1 mdr", 32'(bus_out), 0);

        for (int v = 0; v < NV; v++)
            access(VEC[v][36], VEC[v][35:24], VEC[v][23:8], int'(VEC[v][7:0]));

        // R4: memory-side load beats bus-side load
        @(negedge clk); bus_in = 16'h1111; mdr_load_bus = 1;
        mem_rdata = 16'h2222; mdr_load_mem = 1;
        @(negedge clk); mdr_load_bus = 0; mdr_load_mem = 0;
        #1; chk("R4 mem load priority", 32'(bus_out), 32'h2222);
        chk("R3 bus_out_en low", 32'(bus_out_en), 0);

        // R8: explicit drive of write lines while idle
        mdr_drive_mem = 1; #1;
        chk("R8 wdata_en forced", 32'(mem_wdata_en), 1);
        chk("R8 wdata value", 32'(mem_wdata), 32'h2222);
        @(negedge clk); mdr_drive_mem = 0; #1;
        chk("R8 wdata_en released", 32'(mem_wdata_en), 0);

        // R11: stray completion while idle
        @(negedge clk); mem_cpl = 1; mem_rdata = 16'h9999;
        @(negedge clk); mem_cpl = 0; #1;
        chk("R11 no req", 32'(mem_req), 0);
        chk("R11 mdr kept", 32'(bus_out), 32'h2222);

        // R2: MAR holds without load
        chk("R2 mar hold", 32'(mem_addr), 32'h003);

        // R10: both commands at once while idle
        @(negedge clk); cmd_read = 1; cmd_write = 1;
        @(negedge clk); cmd_read = 0; cmd_write = 0; #1;
        chk("R10 dual cmd ignored", 32'(mem_req), 0);
        chk("R10 dual cmd error", 32'(cmd_error), 1);
        @(negedge clk); #1;
        chk("R10 error one cycle", 32'(cmd_error), 0);

        // R10: command while outstanding
        cmd_read = 1;
        @(negedge clk); cmd_read = 0; cmd_write = 1; #1;
        chk("R10 read outstanding", 32'(mem_req), 1);
        chk("R10 no error on accept", 32'(cmd_error), 0);
        @(negedge clk); cmd_write = 0; #1;
        chk("R10 busy cmd error", 32'(cmd_error), 1);
        chk("R10 kind unchanged", 32'(mem_we), 0);
        // R9: no stall without wait_cpl
        chk("R9 no stall without wait", 32'(stall), 0);
        mem_cpl = 1; mem_rdata = 16'h4321;
        @(negedge clk); mem_cpl = 0; #1;
        chk("R10 error cleared", 32'(cmd_error), 0);
        chk("R10 single access done", 32'(mem_req), 0);
        chk("R6 busy read data", 32'(bus_out), 32'h4321);
        @(negedge clk); #1;
        chk("R10 no second access", 32'(mem_req), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule